// File: doc/BRIEF.md
# Chainable Periodic Down-Counter Bank

This block is a register-mapped bank of periodic timers. It has four 32-bit channels by default, and each one counts down from a programmable load value. When a channel passes zero it raises a sticky interrupt flag and starts the next period from its load value. Each flag drives one interrupt line through a per-channel interrupt enable.

Any channel above channel 0 can be switched into chain mode. In chain mode it advances once for each expiry of the channel directly below it, instead of once per clock. When channel 1 is chained onto channel 0, the pair forms a 64-bit running counter. Software reads that counter as two words, upper first. Reading the upper word captures the lower word in the same cycle, so the two words always belong to the same instant. This holds even when the lower word equals channel 0's load value.

A global control word can do two things. It can halt every channel at once. It can also halt the channels only while an external debug-halt input is high.

Top module: `ptmr_top`

## Requirements
- R1: After reset every register reads 0, every counter is stopped at 0 and every interrupt line is low.
- R2: Register map, with byte offsets and the low two address bits ignored:
  - 0x000 is the global control word. Bit 0 is freeze-on-debug and bit 1 is halt-all.
  - 0x0E0 is the 64-bit counter's upper word and 0x0E4 is its lower word. Both are read-only.
  - Channel n's group starts at 0x100 + 16·n. Within the group, +0 is the load value, +4 the current count (read-only), +8 the channel control and +C the flag.
  - Channel control bit 0 is run, bit 1 is interrupt enable and bit 2 is chain.
- R3: Writing channel control with bit 0 set, while the channel is stopped, loads the count from the load value. A running unchained channel then decrements by one per clock. The cycle in which it advances at count 0 is an expiry, and it reloads the load value, so the period is load+1 clocks. Writing the load value does not disturb the running count.
- R4: An expiry sets the channel's flag (flag register bit 0). Writing 1 to bit 0 of the flag register clears it, and writing 0 does nothing. If an expiry and a clear happen in the same cycle, the expiry wins.
- R5: A channel's interrupt output is high exactly when its flag and its interrupt-enable bit are both 1.
- R6: A channel above 0 with chain set advances only in cycles where the channel below it expires. Channel 0 ignores its chain bit and counts every clock.
- R7: While halt-all (control bit 1) is 1, no channel's count or flag changes through counting.
- R8: While freeze-on-debug (control bit 0) is 1 and the debug-halt input is high, no channel counts. With freeze at 0, debug-halt has no effect.
- R9: A read of the upper word returns channel 1's count and captures channel 0's count in the same cycle. A read of the lower word returns that captured value, not the live count.
- R10: Read data appears on the data output in the cycle after the read strobe and holds until the next read. Unmapped addresses read 0. Writes to read-only locations change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | AW (12) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| dbg_halt | input | 1 | Debug-halt request |
| irq | output | NCH (4) | Per-channel interrupt lines |

## Verification
The bench aims at four corner cases.

- Expiry timing: the advance at count 0 must reload and flag in the same clock. A design that reloads one clock late shows a period of load+2 and a count that sits at zero.
- Upper/lower reads in chained mode: the bench reads the pair many times while channel 0 sweeps through its load value. A design that serves the lower word from the live counter returns a lower word that has moved on from the upper word.
- Clear racing a set: the bench clears a flag in the same cycle as an expiry. A clear-wins design loses that interrupt.
- Halt-all, freeze-on-debug and chain bit 0: the bench toggles each of these. A design that decodes them loosely lets counts drift while they should be held, or stalls channel 0.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   localparam int OFF_GCTL    = 'h000;
   localparam int OFF_WIDE_HI = 'h0E0;
   localparam int OFF_WIDE_LO = 'h0E4;
   localparam int OFF_CH_BASE = 'h100;

   typedef enum logic [1:0] {
      SEL_LOAD = 2'd0,
      SEL_CUR  = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_FLAG = 2'd3
   } ch_sel_e;

   typedef struct packed {
      logic chain;
      logic ie;
      logic run;
   } ch_ctrl_t;
endpackage

// File: rtl/ptmr_chan.sv
module ptmr_chan
   import ptmr_pkg::*;
#(
   parameter int DW       = 32,
   parameter bit IS_FIRST = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_ok,
   input  logic          below_exp,
   input  logic          ld_we,
   input  logic          ctl_we,
   input  logic          flg_we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] cnt,
   output logic [DW-1:0] ld,
   output ch_ctrl_t      ctl,
   output logic          flag,
   output logic          expire,
   output logic          irq
);
   logic step_ok;
   logic adv;

   generate
      if (IS_FIRST) begin : g_free
         assign step_ok = 1'b1;
      end else begin : g_chain
         assign step_ok = !ctl.chain || below_exp;
      end
   endgenerate

   assign adv    = ctl.run && run_ok && step_ok;
   assign expire = adv && (cnt == '0);
   assign irq    = flag && ctl.ie;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld   <= '0;
         ctl  <= '0;
         cnt  <= '0;
         flag <= 1'b0;
      end else begin
         if (ld_we)
            ld <= wdata;
         if (ctl_we)
            ctl <= ch_ctrl_t'(wdata[2:0]);
         if (ctl_we && wdata[0] && !ctl.run)
            cnt <= ld;
         else if (adv)
            cnt <= (cnt == '0) ? ld : cnt - 1'b1;
         if (expire)
            flag <= 1'b1;
         else if (flg_we && wdata[0])
            flag <= 1'b0;
      end
   end
endmodule

// File: rtl/ptmr_wide_snap.sv
module ptmr_wide_snap #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hi_rd,
   input  logic [DW-1:0] lo_live,
   output logic [DW-1:0] lo_held
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         lo_held <= '0;
      else if (hi_rd)
         lo_held <= lo_live;
   end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
   import ptmr_pkg::*;
#(
   parameter int NCH = 4,
   parameter int DW  = 32,
   parameter int AW  = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_wr,
   input  logic           bus_rd,
   input  logic [AW-1:0]  bus_addr,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   input  logic           dbg_halt,
   output logic [NCH-1:0] irq
);
   localparam logic [AW-1:0] A_GCTL = AW'(OFF_GCTL);
   localparam logic [AW-1:0] A_HI   = AW'(OFF_WIDE_HI);
   localparam logic [AW-1:0] A_LO   = AW'(OFF_WIDE_LO);
   localparam logic [AW-9:0] A_PAGE = (AW-8)'(OFF_CH_BASE >> 8);

   if (NCH < 2 || NCH > 16) begin : g_bad_nch
      $error("NCH must be between 2 and 16");
   end
   if (DW < 8) begin : g_bad_dw
      $error("DW must be at least 8");
   end
   if (AW < 9) begin : g_bad_aw
      $error("AW must be at least 9");
   end

   logic [AW-1:0]     waddr;
   logic              ch_hit;
   logic [3:0]        ch_num;
   ch_sel_e           ch_sel;
   logic              frz_q, mdis_q, run_ok;
   logic [NCH*DW-1:0] cnt_flat, ld_flat;
   logic [NCH-1:0]    flag_v, chn_v, exp_v, ie_v, run_v;
   logic [DW-1:0]     snap;
   logic [DW-1:0]     rd_mux;

   assign waddr  = {bus_addr[AW-1:2], 2'b00};
   assign ch_hit = (waddr[AW-1:8] == A_PAGE) && (int'(waddr[7:4]) < NCH);
   assign ch_num = waddr[7:4];
   assign ch_sel = ch_sel_e'(waddr[3:2]);
   assign run_ok = !mdis_q && !(frz_q && dbg_halt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frz_q  <= 1'b0;
         mdis_q <= 1'b0;
      end else if (bus_wr && waddr == A_GCTL) begin
         frz_q  <= bus_wdata[0];
         mdis_q <= bus_wdata[1];
      end
   end

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic     hit_n;
      ch_ctrl_t ctl_n;
      assign hit_n = bus_wr && ch_hit && (ch_num == 4'(n));

      ptmr_chan #(.DW(DW), .IS_FIRST(n == 0)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .run_ok    (run_ok),
         .below_exp ((n == 0) ? 1'b0 : exp_v[(n == 0) ? 0 : n-1]),
         .ld_we     (hit_n && ch_sel == SEL_LOAD),
         .ctl_we    (hit_n && ch_sel == SEL_CTRL),
         .flg_we    (hit_n && ch_sel == SEL_FLAG),
         .wdata     (bus_wdata),
         .cnt       (cnt_flat[n*DW +: DW]),
         .ld        (ld_flat[n*DW +: DW]),
         .ctl       (ctl_n),
         .flag      (flag_v[n]),
         .expire    (exp_v[n]),
         .irq       (irq[n])
      );
      assign chn_v[n] = ctl_n.chain;
      assign ie_v[n]  = ctl_n.ie;
      assign run_v[n] = ctl_n.run;
   end

   ptmr_wide_snap #(.DW(DW)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .hi_rd   (bus_rd && waddr == A_HI),
      .lo_live (cnt_flat[DW-1:0]),
      .lo_held (snap)
   );

   always_comb begin
      rd_mux = '0;
      if (waddr == A_GCTL)
         rd_mux = DW'({mdis_q, frz_q});
      else if (waddr == A_HI)
         rd_mux = cnt_flat[DW +: DW];
      else if (waddr == A_LO)
         rd_mux = snap;
      for (int n = 0; n < NCH; n++) begin
         if (ch_hit && ch_num == 4'(n)) begin
            case (ch_sel)
               SEL_LOAD: rd_mux = ld_flat[n*DW +: DW];
               SEL_CUR:  rd_mux = cnt_flat[n*DW +: DW];
               SEL_CTRL: rd_mux = DW'({chn_v[n], ie_v[n], run_v[n]});
               default:  rd_mux = DW'(flag_v[n]);
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd)
         bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
   parameter int NCH = 4,
   parameter int DW  = 32,
   parameter int AW  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [AW-1:0]     bus_addr,
   input logic              dbg_halt,
   input logic              frz_q,
   input logic              mdis_q,
   input logic [NCH*DW-1:0] cnt_flat,
   input logic [NCH*DW-1:0] ld_flat,
   input logic [NCH-1:0]    flag_v,
   input logic [NCH-1:0]    chn_v,
   input logic [NCH-1:0]    exp_v,
   input logic [DW-1:0]     snap
);
   for (genvar n = 0; n < NCH; n++) begin : g_chk
      a_r4_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
         exp_v[n] |=> flag_v[n]);
      a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
         (exp_v[n] && !bus_wr) |=> cnt_flat[n*DW +: DW] == $past(ld_flat[n*DW +: DW]));
      a_r7_halt_all: assert property (@(posedge clk) disable iff (!rst_n)
         (mdis_q && !bus_wr) |=> $stable(cnt_flat[n*DW +: DW]));
      a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
         (frz_q && dbg_halt && !bus_wr) |=> $stable(cnt_flat[n*DW +: DW]));
      if (n > 0) begin : g_chain
         a_r6_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (chn_v[n] && !exp_v[n-1] && !bus_wr) |=> $stable(cnt_flat[n*DW +: DW]));
      end
   end

   a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && {bus_addr[AW-1:2], 2'b00} == AW'('h0E0)) |=> snap == $past(cnt_flat[DW-1:0]));
endmodule

bind ptmr_top ptmr_checker #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_addr (bus_addr),
   .dbg_halt (dbg_halt),
   .frz_q    (frz_q),
   .mdis_q   (mdis_q),
   .cnt_flat (cnt_flat),
   .ld_flat  (ld_flat),
   .flag_v   (flag_v),
   .chn_v    (chn_v),
   .exp_v    (exp_v),
   .snap     (snap)
);

// File: tb/sim_ptmr_top.sv
module sim_ptmr_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, dbg_halt = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptmr_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dbg_halt(dbg_halt), .irq(irq)
   );

   // Behavioural model written from the requirements
   logic [31:0] m_ld [4];
   logic [31:0] m_cnt [4];
   logic [2:0]  m_ctl [4];
   logic        m_flag [4];
   logic        m_frz, m_mdis;
   logic [31:0] m_snap, m_rdata;

   function automatic logic [31:0] mdl_read(input logic [11:0] a);
      logic [11:0] w;
      w = {a[11:2], 2'b00};
      if (w == 12'h000) return {30'b0, m_mdis, m_frz};
      if (w == 12'h0E0) return m_cnt[1];
      if (w == 12'h0E4) return m_snap;
      if (w >= 12'h100 && w < 12'h140) begin
         case (w[3:2])
            2'd0: return m_ld[w[5:4]];
            2'd1: return m_cnt[w[5:4]];
            2'd2: return {29'b0, m_ctl[w[5:4]]};
            default: return {31'b0, m_flag[w[5:4]]};
         endcase
      end
      return 32'h0;
   endfunction

   function automatic logic [11:0] ch_addr(input int n, input int sel);
      return 12'(32'h100 + 16*n + 4*sel);
   endfunction

   always @(posedge clk) begin
      logic run;
      logic adv [4];
      logic ex [4];
      if (!rst_n) begin
         for (int n = 0; n < 4; n++) begin
            m_ld[n] = 0; m_cnt[n] = 0; m_ctl[n] = 0; m_flag[n] = 0;
         end
         m_frz = 0; m_mdis = 0; m_snap = 0; m_rdata = 0;
      end else begin
         run = !m_mdis && !(m_frz && dbg_halt);
         for (int n = 0; n < 4; n++) begin
            adv[n] = m_ctl[n][0] && run &&
                     (n == 0 || !m_ctl[n][2] || ex[(n == 0) ? 0 : n-1]);
            ex[n]  = adv[n] && (m_cnt[n] == 0);
         end
         if (bus_rd) begin
            m_rdata = mdl_read(bus_addr);
            if ({bus_addr[11:2], 2'b00} == 12'h0E0) m_snap = m_cnt[0];
         end
         for (int n = 0; n < 4; n++) begin
            if (bus_wr && bus_addr == ch_addr(n, 2) && bus_wdata[0] && !m_ctl[n][0])
               m_cnt[n] = m_ld[n];
            else if (adv[n])
               m_cnt[n] = (m_cnt[n] == 0) ? m_ld[n] : m_cnt[n] - 1;
            if (ex[n]) m_flag[n] = 1;
            else if (bus_wr && bus_addr == ch_addr(n, 3) && bus_wdata[0]) m_flag[n] = 0;
            if (bus_wr && bus_addr == ch_addr(n, 0)) m_ld[n] = bus_wdata;
            if (bus_wr && bus_addr == ch_addr(n, 2)) m_ctl[n] = bus_wdata[2:0];
         end
         if (bus_wr && bus_addr == 12'h000) begin
            m_frz = bus_wdata[0]; m_mdis = bus_wdata[1];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // R5: interrupt lines against model every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int n = 0; n < 4; n++)
            chk("R5 irq", {31'b0, irq[n]}, {31'b0, m_flag[n] & m_ctl[n][1]});
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input logic [11:0] a, input string tag);
      bus_rd = 1; bus_addr = a;
      @(negedge clk);
      bus_rd = 0;
      chk(tag, bus_rdata, m_rdata);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 irq", {28'b0, irq}, 32'h0);
      rd(12'h000, "R1 gctl");
      rd(12'h0E0, "R1 hi");
      rd(12'h0E4, "R1 lo");
      for (int n = 0; n < 4; n++) begin
         chk("R1 ld", mdl_read(ch_addr(n, 0)), 32'h0);
         rd(ch_addr(n, 1), "R1 cnt");
         rd(ch_addr(n, 3), "R1 flag");
      end
      // R3/R2 basic periodic count on channel 2
      wr(ch_addr(2, 0), 32'd5);
      wr(ch_addr(2, 2), 32'h3);
      for (int k = 0; k < 8; k++) rd(ch_addr(2, 1), "R3 count");
      rd(ch_addr(2, 3), "R4 flag set");
      wr(ch_addr(2, 3), 32'h0);
      rd(ch_addr(2, 3), "R4 write0 no effect");
      wr(ch_addr(2, 3), 32'h1);
      rd(ch_addr(2, 3), "R4 clear");
      wr(ch_addr(2, 0), 32'd9);
      rd(ch_addr(2, 1), "R3 load write no disturb");
      // R4 expiry-vs-clear race: chan 3 with load 0 expires each cycle
      wr(ch_addr(3, 2), 32'h3);
      wr(ch_addr(3, 3), 32'h1);
      rd(ch_addr(3, 3), "R4 set wins");
      // R6 chain bit ignored on channel 0, channel 1 chained
      wr(ch_addr(0, 0), 32'd3);
      wr(ch_addr(1, 0), 32'd4);
      wr(ch_addr(0, 2), 32'h5);
      wr(ch_addr(1, 2), 32'h5);
      for (int k = 0; k < 40; k++) begin
         rd(12'h0E0, "R9 hi");
         rd(12'h0E4, "R9 lo coherent");
         rd(ch_addr(0, 1), "R6 ch0 ignores chain");
      end
      // R7 halt-all
      wr(12'h000, 32'h2);
      rd(ch_addr(2, 1), "R7 halt");
      idle(5);
      rd(ch_addr(2, 1), "R7 held");
      // R8 freeze on debug
      wr(12'h000, 32'h1);
      dbg_halt = 1;
      rd(ch_addr(0, 1), "R8 frozen");
      idle(4);
      rd(ch_addr(0, 1), "R8 held");
      dbg_halt = 0;
      idle(3);
      rd(ch_addr(0, 1), "R8 resumes");
      wr(12'h000, 32'h0);
      dbg_halt = 1;
      idle(2);
      rd(ch_addr(0, 1), "R8 no freeze bit");
      dbg_halt = 0;
      // R10 unmapped and read-only writes
      rd(12'h080, "R10 unmapped");
      rd(12'h1F0, "R10 unmapped channel");
      wr(ch_addr(2, 1), 32'hDEAD);
      rd(ch_addr(2, 1), "R10 ro cnt");
      wr(12'h0E4, 32'hBEEF);
      rd(12'h0E4, "R10 ro lo");
      // Random mix
      for (int i = 0; i < 3000; i++) begin
         int op, n, s;
         op = $urandom_range(0, 19);
         n  = $urandom_range(0, 3);
         s  = $urandom_range(0, 3);
         dbg_halt = ($urandom_range(0, 7) == 0);
         if (op < 4)       wr(ch_addr(n, 0), $urandom_range(0, 12));
         else if (op < 6)  wr(ch_addr(n, 2), $urandom_range(0, 7));
         else if (op < 7)  wr(ch_addr(n, 3), $urandom_range(0, 1));
         else if (op < 8)  wr(12'h000, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3) : 0);
         else if (op < 13) rd(ch_addr(n, s), "R3 random channel read");
         else if (op < 16) begin
            rd(12'h0E0, "R9 random hi");
            rd(12'h0E4, "R9 random lo");
         end
         else if (op < 17) rd(12'h000, "R2 random gctl");
         else idle(1);
      end
      dbg_halt = 0;
      idle(2);
      finish_run();
   end
endmodule